// File: doc/BRIEF.md
# Tile Score Gate for Block-Sparse Attention

This block watches the score elements of one query-tile by key-tile product as they stream out of the score stage, one element per cycle. It tracks the largest score seen in the tile. When the tile's final element arrives, it compares that maximum with a calibrated threshold. A writable table holds one threshold for each (head, block position) pair, and the tile's head and block indices select the entry. The result is a keep or skip verdict. A keep verdict lets the downstream engine fetch the value tile and run the probability-times-value product. A skip verdict suppresses both operations. Kept tiles pass on untouched and are processed exactly.

The first tile of every query row is always kept, so the running softmax statistics of that row start from real data. A saturating counter records the number of skipped tiles, and a control input clears it. The threshold table is loaded through a plain write port before tiles are streamed.

Top module: `tile_gate_filter`

## Requirements
- R1: The tile maximum is the largest signed two's-complement score among the elements of a tile. The verdict is keep (`dec_keep`=1) when that maximum is greater than or equal to the selected threshold, and skip otherwise.
- R2: The threshold comes from table entry `{s_head, s_blk}`, with the head index in the upper bits. An entry is written when `cfg_we`=1, at address `cfg_addr` with data `cfg_data`, and the new value governs tiles whose last element arrives on a later cycle.
- R3: `dec_valid` pulses for exactly one cycle, in the cycle after a tile's last element (`s_valid`=1 and `s_last`=1) is accepted. `dec_keep` is 0 whenever `dec_valid` is 0.
- R4: A tile whose last element carries `s_row_first`=1 is always kept, whatever its maximum.
- R5: `skip_cnt` rises by one in the same cycle that a skip verdict is shown, and is otherwise unchanged unless it is cleared.
- R6: `skip_cnt` saturates at 2^CNT_W-1 and never wraps.
- R7: `cnt_clr`=1 clears `skip_cnt` to 0 on the next cycle, taking priority over an increment in that same cycle.
- R8: After reset, `dec_valid`, `dec_keep` and `skip_cnt` are 0, and the next accepted element starts a new tile.
- R9: Cycles with `s_valid`=0 inside a tile leave the running maximum unchanged.
- R10: A tile of a single element (`s_last` on its first element) is judged on that element alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold table write enable |
| cfg_addr | input | HEAD_W+BLK_W | Table entry, {head, block} |
| cfg_data | input | SCORE_W | Signed threshold to store |
| s_valid | input | 1 | Score element valid |
| s_data | input | SCORE_W | Signed score element |
| s_last | input | 1 | Final element of the tile |
| s_head | input | HEAD_W | Head index, sampled with the last element |
| s_blk | input | BLK_W | Block index, sampled with the last element |
| s_row_first | input | 1 | Tile is the first of its query row, sampled with the last element |
| cnt_clr | input | 1 | Clear the skip counter |
| dec_valid | output | 1 | Verdict strobe |
| dec_keep | output | 1 | 1 = issue value load and multiply, 0 = skip the tile |
| skip_cnt | output | CNT_W | Saturating count of skipped tiles |

## Verification
A tile's verdict and its effect on the skip count both show up in the cycle after its last element is taken, through one register stage. A threshold write takes effect for a last element accepted one cycle later. The bench drives inputs shortly after each rising edge and advances a behavioural model at that edge. It compares all three outputs at the falling edge, so each expected value is checked in the cycle it is due. Directed checks for equality with the threshold, row-first override, gaps, single-element tiles, saturation and clear-versus-increment are sampled just after the edge that registers the verdict.

// File: rtl/tgf_pkg.sv
package tgf_pkg;
  // registered verdict of one tile
  typedef struct packed {
    logic valid;
    logic keep;
  } tgf_dec_t;
endpackage

// File: rtl/tgf_max_track.sv
module tgf_max_track #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] in_data,
  input  logic                in_last,
  output logic signed [W-1:0] tile_max
);
  logic signed [W-1:0] run_max_q, run_max_d;
  logic                mid_q, mid_d;
  logic                upd_en;

  // maximum including the element on the bus this cycle
  always_comb begin
    if (mid_q && (run_max_q > in_data)) tile_max = run_max_q;
    else                                tile_max = in_data;
  end

  assign upd_en    = in_valid;
  assign mid_d     = ~in_last;
  assign run_max_d = tile_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q     <= 1'b0;
      run_max_q <= '0;
    end else if (upd_en) begin
      mid_q     <= mid_d;
      run_max_q <= run_max_d;
    end
  end
endmodule

// File: rtl/tgf_thr_table.sv
module tgf_thr_table #(
  parameter int W     = 16,
  parameter int AW    = 5,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic signed [W-1:0] rdata
);
  logic signed [W-1:0] entry_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wen;
    assign wen = we && (waddr == AW'(g));
    always_ff @(posedge clk) begin
      if (wen) entry_q[g] <= wdata;
    end
  end

  assign rdata = entry_q[raddr];
endmodule

// File: rtl/tgf_sat_count.sv
module tgf_sat_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != TOP));
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tile_gate_filter.sv
module tile_gate_filter #(
  parameter int SCORE_W = 16,
  parameter int HEADS   = 4,
  parameter int BLOCKS  = 8,
  parameter int CNT_W   = 8,
  localparam int HEAD_W = (HEADS > 1) ? $clog2(HEADS) : 1,
  localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int ADDR_W = HEAD_W + BLK_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic signed [SCORE_W-1:0] cfg_data,
  input  logic                      s_valid,
  input  logic signed [SCORE_W-1:0] s_data,
  input  logic                      s_last,
  input  logic [HEAD_W-1:0]         s_head,
  input  logic [BLK_W-1:0]          s_blk,
  input  logic                      s_row_first,
  input  logic                      cnt_clr,
  output logic                      dec_valid,
  output logic                      dec_keep,
  output logic [CNT_W-1:0]          skip_cnt
);
  import tgf_pkg::*;

  logic signed [SCORE_W-1:0] tile_max;
  logic signed [SCORE_W-1:0] thr;
  tgf_dec_t                  dec_q, dec_d;
  logic                      skip_now;

  tgf_max_track #(.W(SCORE_W)) u_max (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .in_data  (s_data),
    .in_last  (s_last),
    .tile_max (tile_max)
  );

  tgf_thr_table #(.W(SCORE_W), .AW(ADDR_W)) u_tab (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_data),
    .raddr ({s_head, s_blk}),
    .rdata (thr)
  );

  always_comb begin
    dec_d.valid = s_valid && s_last;
    dec_d.keep  = dec_d.valid && (s_row_first || (tile_max >= thr));
    skip_now    = dec_d.valid && !dec_d.keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dec_q <= '0;
    else        dec_q <= dec_d;
  end

  tgf_sat_count #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (skip_now),
    .count (skip_cnt)
  );

  assign dec_valid = dec_q.valid;
  assign dec_keep  = dec_q.keep;
endmodule

// File: rtl/tgf_checker.sv
module tgf_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_last,
  input logic             s_row_first,
  input logic             cnt_clr,
  input logic             dec_valid,
  input logic             dec_keep,
  input logic [CNT_W-1:0] skip_cnt
);
  // R3
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid == $past(s_valid && s_last));
  // R3
  keep_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !dec_keep);
  // R4
  row_first_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(s_row_first)) |-> dec_keep);
  // R5
  skip_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> ((skip_cnt == $past(skip_cnt)) ||
      (({1'b0, skip_cnt} == ({1'b0, $past(skip_cnt)} + 1'b1)) && dec_valid && !dec_keep)));
  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_clr) |-> (skip_cnt >= $past(skip_cnt)));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_clr) |-> (skip_cnt == '0));
endmodule

bind tile_gate_filter tgf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_valid     (s_valid),
  .s_last      (s_last),
  .s_row_first (s_row_first),
  .cnt_clr     (cnt_clr),
  .dec_valid   (dec_valid),
  .dec_keep    (dec_keep),
  .skip_cnt    (skip_cnt)
);

// File: tb/tile_gate_filter_tb.sv
module tile_gate_filter_tb;
  localparam int SW = 16, HW = 2, BW = 3, CW = 8, AW = HW + BW;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [AW-1:0] cfg_addr;
  logic signed [SW-1:0] cfg_data;
  logic s_valid, s_last, s_row_first, cnt_clr;
  logic signed [SW-1:0] s_data;
  logic [HW-1:0] s_head;
  logic [BW-1:0] s_blk;
  logic dec_valid, dec_keep;
  logic [CW-1:0] skip_cnt;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tile_gate_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
    .s_head(s_head), .s_blk(s_blk), .s_row_first(s_row_first),
    .cnt_clr(cnt_clr), .dec_valid(dec_valid), .dec_keep(dec_keep),
    .skip_cnt(skip_cnt)
  );

  // behavioural reference model
  int  thr_m [32];
  int  m_max, m_cnt;
  bit  m_in, m_valid, m_keep;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in = 0; m_valid = 0; m_keep = 0; m_cnt = 0; m_max = 0;
    end else begin
      int cur;
      bit nv, nk;
      nv = 0; nk = 0;
      if (s_valid) begin
        cur = int'(s_data);
        if (m_in && m_max > cur) cur = m_max;
        if (s_last) begin
          nv = 1;
          nk = s_row_first || (cur >= thr_m[{s_head, s_blk}]);
          m_in = 0;
        end else begin
          m_in = 1;
          m_max = cur;
        end
      end
      if (cnt_clr) m_cnt = 0;
      else if (nv && !nk && m_cnt < CMAX) m_cnt = m_cnt + 1;
      m_valid = nv; m_keep = nk;
      if (cfg_we) thr_m[cfg_addr] = int'(cfg_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total += 3;
      if (dec_valid !== m_valid) begin
        bad++; $display("FAIL R3 dec_valid actual=%0b expected=%0b", dec_valid, m_valid);
      end
      if (dec_keep !== m_keep) begin
        bad++; $display("FAIL R1 R4 dec_keep actual=%0b expected=%0b", dec_keep, m_keep);
      end
      if (int'(skip_cnt) != m_cnt) begin
        bad++; $display("FAIL R5 skip_cnt actual=%0d expected=%0d", skip_cnt, m_cnt);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_thr(input int h, input int b, input int val);
    @(posedge clk); #2;
    cfg_we = 1; cfg_addr = AW'((h << BW) | b); cfg_data = SW'(val);
    @(posedge clk); #2;
    cfg_we = 0;
  endtask

  // streams one tile; returns just after the edge that registers the verdict
  task automatic run_tile(input int h, input int b, input bit first, input bit gap,
                          input bit clr, input int n, input int v[8]);
    for (int i = 0; i < n; i++) begin
      if (gap && i > 0) begin
        @(posedge clk); #2; s_valid = 0;
      end
      @(posedge clk); #2;
      s_valid = 1; s_data = SW'(v[i]); s_last = (i == n - 1);
      s_head = HW'(h); s_blk = BW'(b); s_row_first = first;
      cnt_clr = clr && (i == n - 1);
    end
    @(posedge clk); #2;
    s_valid = 0; s_last = 0; s_row_first = 0; cnt_clr = 0;
  endtask

  task automatic check_dec(input string tag, input bit exp_keep);
    check({tag, " valid"}, int'(dec_valid), 1);
    check({tag, " keep"}, int'(dec_keep), int'(exp_keep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = '0; cfg_data = '0;
    s_valid = 0; s_data = '0; s_last = 0; s_head = '0; s_blk = '0;
    s_row_first = 0; cnt_clr = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R8 reset state
    check("R8 dec_valid", int'(dec_valid), 0);
    check("R8 dec_keep", int'(dec_keep), 0);
    check("R8 skip_cnt", int'(skip_cnt), 0);

    for (int a = 0; a < 32; a++) wr_thr(a >> BW, a & 7, ((a * 37) % 200) - 100);

    // R1 equality keeps, one below skips
    wr_thr(1, 3, 50);
    run_tile(1, 3, 0, 0, 0, 3, '{10, 50, -7, 0, 0, 0, 0, 0});
    check_dec("R1 equal", 1);
    run_tile(1, 3, 0, 0, 0, 3, '{49, -50, 12, 0, 0, 0, 0, 0});
    check_dec("R1 below", 0);
    check("R5 count after skip", int'(skip_cnt), 1);
    // R1 all negative scores
    wr_thr(0, 0, -20);
    run_tile(0, 0, 0, 0, 0, 4, '{-90, -21, -300, -40, 0, 0, 0, 0});
    check_dec("R1 negative skip", 0);
    run_tile(0, 0, 0, 0, 0, 4, '{-90, -19, -300, -40, 0, 0, 0, 0});
    check_dec("R1 negative keep", 1);

    // R2 indexing by {head, blk}
    wr_thr(2, 5, 100);
    wr_thr(2, 4, -100);
    run_tile(2, 5, 0, 0, 0, 2, '{99, 0, 0, 0, 0, 0, 0, 0});
    check_dec("R2 entry 2/5", 0);
    run_tile(2, 4, 0, 0, 0, 2, '{99, 0, 0, 0, 0, 0, 0, 0});
    check_dec("R2 entry 2/4", 1);
    wr_thr(2, 5, 90);
    run_tile(2, 5, 0, 0, 0, 2, '{99, 0, 0, 0, 0, 0, 0, 0});
    check_dec("R2 rewritten", 1);

    // R4 row-first override
    run_tile(2, 5, 1, 0, 0, 2, '{-500, -600, 0, 0, 0, 0, 0, 0});
    check_dec("R4 first kept", 1);

    // R9 gaps inside the tile
    wr_thr(3, 7, 40);
    run_tile(3, 7, 0, 1, 0, 3, '{5, 40, -3, 0, 0, 0, 0, 0});
    check_dec("R9 gap keep", 1);

    // R10 single-element tiles
    run_tile(3, 7, 0, 0, 0, 1, '{40, 0, 0, 0, 0, 0, 0, 0});
    check_dec("R10 single keep", 1);
    run_tile(3, 7, 0, 0, 0, 1, '{39, 0, 0, 0, 0, 0, 0, 0});
    check_dec("R10 single skip", 0);

    // random traffic against the model
    for (int t = 0; t < 300; t++) begin
      int vals[8];
      int n;
      n = 1 + int'($urandom_range(5));
      for (int k = 0; k < 8; k++) vals[k] = int'($urandom_range(399)) - 200;
      run_tile(int'($urandom_range(3)), int'($urandom_range(7)),
               ($urandom_range(7) == 0), $urandom_range(1) == 1, 0, n, vals);
    end

    // R6 saturation
    wr_thr(1, 1, 0);
    for (int t = 0; t < CMAX + 5; t++)
      run_tile(1, 1, 0, 0, 0, 1, '{-1000, 0, 0, 0, 0, 0, 0, 0});
    check("R6 saturated", int'(skip_cnt), CMAX);

    // R7 clear wins over a simultaneous skip
    run_tile(1, 1, 0, 0, 1, 1, '{-1000, 0, 0, 0, 0, 0, 0, 0});
    check("R7 clear priority", int'(skip_cnt), 0);
    run_tile(1, 1, 0, 0, 0, 1, '{-1000, 0, 0, 0, 0, 0, 0, 0});
    check("R7 count after clear", int'(skip_cnt), 1);

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule